// File: doc/BRIEF.md
# Round Object Pixel Renderer with Priority Compositing

This block produces the 3-bit colour of each screen pixel directly from its coordinates. It keeps no frame memory. A raster scanner presents one pixel coordinate pair per clock on `pix_x`/`pix_y`, in the range (0,0) to (639,479), as 10-bit unsigned values. A `video_on` flag marks the visible area. Three clocks later the block returns the colour for that pixel on `rgb_out`.

The block draws three shapes over a yellow background:

- a fixed vertical blue stripe (the wall);
- a fixed green rectangle (the paddle);
- a red filled disc.

The disc is set by a centre and a radius. A pixel is inside the disc when the sum of the squared coordinate differences is not greater than the squared radius. A bounding-box check gates this test. The distance arithmetic is split over two register stages. The flags of the other shapes travel alongside it so that all of them stay aligned.

New disc parameters are written through a load strobe. They are held as pending values and applied only when pixel (0,0) is presented, so a frame is never drawn with two different discs. Motion, sync timing and bitmap shapes are handled elsewhere.

Top module: `orb_compositor`

## Requirements
- R1: While `rst_n` is low, and on the first sample after its release, `rgb_out` is 000.
- R2: The colour for a coordinate pair presented before clock edge k appears on `rgb_out` after edge k+2, which is a fixed latency of three clocks. A new pixel can be accepted every clock.
- R3: When `video_on` was low for a pixel, its colour is 000 (blank), whatever shape covers it.
- R4: When `video_on` is high and 32 <= x <= 35, for any y, the colour is blue 001. The wall has the highest priority, over both paddle and disc.
- R5: When `video_on` is high, the pixel is not on the wall, and 600 <= x <= 603 and 204 <= y <= 275, the colour is green 010. The paddle wins over the disc. All four edges are inclusive.
- R6: Otherwise, a visible pixel is red 100 when (x-cx)^2 + (y-cy)^2 <= r^2. Equality counts as inside. Centres near coordinate 0 work correctly, including when cx-r or cy-r is negative.
- R7: A visible pixel that is covered by none of the three shapes is yellow 110. No other code value ever appears on `rgb_out`.
- R8: A pulse on `ld_stb` captures `ld_cx`, `ld_cy` and `ld_r` as pending values. These values have no effect on any pixel until a pixel with x=0 and y=0 is presented. That pixel, and all pixels after it, use the new values.
- R9: A strobe given in the same cycle as pixel (0,0) does not affect the frame that starts there. It waits for the next (0,0). When several strobes come before a frame start, the last one wins.
- R10: After reset the disc has centre (320,240) and radius 16.
- R11: A radius of 0 draws exactly the single centre pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 10 | Column of the current pixel |
| pix_y | input | 10 | Row of the current pixel |
| video_on | input | 1 | High when the pixel lies in the visible area |
| ld_stb | input | 1 | One-cycle strobe that captures new disc parameters |
| ld_cx | input | 10 | New disc centre column |
| ld_cy | input | 10 | New disc centre row |
| ld_r | input | 10 | New disc radius |
| rgb_out | output | 3 | Pixel colour, bit 2 red, bit 1 green, bit 0 blue |

## Verification
The bench builds the block with its default parameters: 10-bit coordinates, wall at columns 32 to 35, paddle at 600..603 by 204..275, and a reset disc of radius 16 at (320,240). With these values, every priority overlap can be reached on a 640x480 screen: wall over disc, and paddle over disc. Radii range from 0 up to 63. Centres placed at coordinate 0 push the lower bounding-box limit below zero. The bench tests inclusive edges on both sides of each shape, and strobes that fall in the same cycle as the frame-start pixel.

// File: rtl/orb_pkg.sv
package orb_pkg;
  typedef logic [2:0] rgb_t;
  localparam rgb_t C_BLANK = 3'b000;
  localparam rgb_t C_WALL  = 3'b001;
  localparam rgb_t C_PAD   = 3'b010;
  localparam rgb_t C_BALL  = 3'b100;
  localparam rgb_t C_BACK  = 3'b110;
endpackage

// File: rtl/orb_coord_regs.sv
// Holds the active and pending disc parameters. Pending values are
// committed when pixel (0,0) is presented; that pixel already uses them.
module orb_coord_regs #(
  parameter int CW     = 10,
  parameter int DEF_CX = 320,
  parameter int DEF_CY = 240,
  parameter int DEF_R  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          ld_stb,
  input  logic [CW-1:0] ld_cx,
  input  logic [CW-1:0] ld_cy,
  input  logic [CW-1:0] ld_r,
  output logic [CW-1:0] use_cx,
  output logic [CW-1:0] use_cy,
  output logic [CW-1:0] use_r,
  output logic [CW-1:0] act_cx,
  output logic [CW-1:0] act_cy,
  output logic [CW-1:0] act_r
);
  logic          pend_vld;
  logic [CW-1:0] pend_cx, pend_cy, pend_r;
  logic          frame_start, commit;

  assign frame_start = (pix_x == '0) && (pix_y == '0);
  assign commit      = frame_start && pend_vld;

  assign use_cx = commit ? pend_cx : act_cx;
  assign use_cy = commit ? pend_cy : act_cy;
  assign use_r  = commit ? pend_r  : act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cx <= CW'(DEF_CX);
      act_cy <= CW'(DEF_CY);
      act_r  <= CW'(DEF_R);
    end else if (commit) begin
      act_cx <= pend_cx;
      act_cy <= pend_cy;
      act_r  <= pend_r;
    end
  end

  // A strobe in the commit cycle refills the pending set for the next frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_cx  <= '0;
      pend_cy  <= '0;
      pend_r   <= '0;
    end else if (ld_stb) begin
      pend_vld <= 1'b1;
      pend_cx  <= ld_cx;
      pend_cy  <= ld_cy;
      pend_r   <= ld_r;
    end else if (commit) begin
      pend_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/orb_rect_hits.sv
// Fixed rectangle membership, inclusive on every edge.
module orb_rect_hits #(
  parameter int CW     = 10,
  parameter int WALL_L = 32,
  parameter int WALL_R = 35,
  parameter int PAD_L  = 600,
  parameter int PAD_R  = 603,
  parameter int PAD_T  = 204,
  parameter int PAD_B  = 275
) (
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  output logic          wall_hit,
  output logic          pad_hit
);
  assign wall_hit = (pix_x >= CW'(WALL_L)) && (pix_x <= CW'(WALL_R));
  assign pad_hit  = (pix_x >= CW'(PAD_L)) && (pix_x <= CW'(PAD_R)) &&
                    (pix_y >= CW'(PAD_T)) && (pix_y <= CW'(PAD_B));
endmodule

// File: rtl/orb_circle_pipe.sv
// Two-stage disc test: stage 1 forms signed differences and the bounding
// box, stage 2 squares them; the final sum and compare feed the output mux.
module orb_circle_pipe #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [CW-1:0] rad,
  output logic          ball_hit
);
  localparam int DW   = CW + 1;
  localparam int BW   = CW + 2;
  localparam int SQW  = 2 * DW - 1;
  localparam int SUMW = SQW + 1;

  logic signed [DW-1:0] dx_d, dy_d, dx_q, dy_q;
  logic signed [BW-1:0] xs, ys, xlo, xhi, ylo, yhi;
  logic                 box_d, box_q, box_q2;
  logic [CW-1:0]        r_q;
  logic signed [SQW-1:0] dxw, dyw;
  logic [SQW-1:0]       sqx_q, sqy_q, r2_q;
  logic [SUMW-1:0]      dist2;

  assign dx_d = $signed({1'b0, pix_x}) - $signed({1'b0, cx});
  assign dy_d = $signed({1'b0, pix_y}) - $signed({1'b0, cy});

  assign xs  = $signed({2'b00, pix_x});
  assign ys  = $signed({2'b00, pix_y});
  assign xlo = $signed({2'b00, cx}) - $signed({2'b00, rad});
  assign xhi = $signed({2'b00, cx}) + $signed({2'b00, rad});
  assign ylo = $signed({2'b00, cy}) - $signed({2'b00, rad});
  assign yhi = $signed({2'b00, cy}) + $signed({2'b00, rad});
  assign box_d = (xs >= xlo) && (xs <= xhi) && (ys >= ylo) && (ys <= yhi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dx_q  <= '0;
      dy_q  <= '0;
      r_q   <= '0;
      box_q <= 1'b0;
    end else begin
      dx_q  <= dx_d;
      dy_q  <= dy_d;
      r_q   <= rad;
      box_q <= box_d;
    end
  end

  assign dxw = SQW'(dx_q);
  assign dyw = SQW'(dy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqx_q  <= '0;
      sqy_q  <= '0;
      r2_q   <= '0;
      box_q2 <= 1'b0;
    end else begin
      sqx_q  <= $unsigned(dxw * dxw);
      sqy_q  <= $unsigned(dyw * dyw);
      r2_q   <= SQW'(r_q) * SQW'(r_q);
      box_q2 <= box_q;
    end
  end

  assign dist2    = SUMW'(sqx_q) + SUMW'(sqy_q);
  assign ball_hit = box_q2 && (dist2 <= SUMW'(r2_q));
endmodule

// File: rtl/orb_compositor.sv
module orb_compositor #(
  parameter int CW     = 10,
  parameter int WALL_L = 32,
  parameter int WALL_R = 35,
  parameter int PAD_L  = 600,
  parameter int PAD_R  = 603,
  parameter int PAD_T  = 204,
  parameter int PAD_B  = 275,
  parameter int DEF_CX = 320,
  parameter int DEF_CY = 240,
  parameter int DEF_R  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          video_on,
  input  logic          ld_stb,
  input  logic [CW-1:0] ld_cx,
  input  logic [CW-1:0] ld_cy,
  input  logic [CW-1:0] ld_r,
  output logic [2:0]    rgb_out
);
  import orb_pkg::*;

  localparam int FLAG_DLY = 2;

  logic [CW-1:0] use_cx, use_cy, use_r, act_cx, act_cy, act_r;
  logic          wall_hit, pad_hit, ball_hit;
  logic [FLAG_DLY-1:0] von_d, wall_d, pad_d;
  rgb_t          rgb_next;

  orb_coord_regs #(.CW(CW), .DEF_CX(DEF_CX), .DEF_CY(DEF_CY), .DEF_R(DEF_R)) u_regs (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .ld_stb(ld_stb), .ld_cx(ld_cx), .ld_cy(ld_cy), .ld_r(ld_r),
    .use_cx(use_cx), .use_cy(use_cy), .use_r(use_r),
    .act_cx(act_cx), .act_cy(act_cy), .act_r(act_r)
  );

  orb_rect_hits #(.CW(CW), .WALL_L(WALL_L), .WALL_R(WALL_R), .PAD_L(PAD_L),
                  .PAD_R(PAD_R), .PAD_T(PAD_T), .PAD_B(PAD_B)) u_rect (
    .pix_x(pix_x), .pix_y(pix_y), .wall_hit(wall_hit), .pad_hit(pad_hit)
  );

  orb_circle_pipe #(.CW(CW)) u_disc (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .cx(use_cx), .cy(use_cy), .rad(use_r), .ball_hit(ball_hit)
  );

  // Keep the cheap flags aligned with the two-stage disc test.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      von_d  <= '0;
      wall_d <= '0;
      pad_d  <= '0;
    end else begin
      von_d  <= {von_d[FLAG_DLY-2:0], video_on};
      wall_d <= {wall_d[FLAG_DLY-2:0], wall_hit};
      pad_d  <= {pad_d[FLAG_DLY-2:0], pad_hit};
    end
  end

  always_comb begin
    if (!von_d[FLAG_DLY-1])      rgb_next = C_BLANK;
    else if (wall_d[FLAG_DLY-1]) rgb_next = C_WALL;
    else if (pad_d[FLAG_DLY-1])  rgb_next = C_PAD;
    else if (ball_hit)           rgb_next = C_BALL;
    else                         rgb_next = C_BACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_out <= C_BLANK;
    else        rgb_out <= rgb_next;
  end
endmodule

// File: rtl/orb_compositor_chk.sv
module orb_compositor_chk #(
  parameter int CW     = 10,
  parameter int WALL_L = 32,
  parameter int WALL_R = 35,
  parameter int PAD_L  = 600,
  parameter int PAD_R  = 603,
  parameter int PAD_T  = 204,
  parameter int PAD_B  = 275
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] pix_y,
  input logic          video_on,
  input logic [2:0]    rgb_out,
  input logic [CW-1:0] act_cx,
  input logic [CW-1:0] act_cy,
  input logic [CW-1:0] act_r
);
  logic [1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  AST_RESET_BLANK: assert property (@(posedge clk) !rst_n |=> rgb_out == 3'b000); // R1
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && !$past(video_on, 3)) |-> rgb_out == 3'b000); // R3
  AST_WALL_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && $past(video_on, 3) && $past(pix_x, 3) >= CW'(WALL_L) &&
     $past(pix_x, 3) <= CW'(WALL_R)) |-> rgb_out == 3'b001); // R4
  AST_PAD_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && $past(video_on, 3) && $past(pix_x, 3) >= CW'(PAD_L) &&
     $past(pix_x, 3) <= CW'(PAD_R) && $past(pix_y, 3) >= CW'(PAD_T) &&
     $past(pix_y, 3) <= CW'(PAD_B)) |-> rgb_out == 3'b010); // R5
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_out inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b110}); // R7
  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0 && !($past(pix_x) == '0 && $past(pix_y) == '0)) |->
    ($stable(act_cx) && $stable(act_cy) && $stable(act_r))); // R8
endmodule

bind orb_compositor orb_compositor_chk #(
  .CW(CW), .WALL_L(WALL_L), .WALL_R(WALL_R), .PAD_L(PAD_L),
  .PAD_R(PAD_R), .PAD_T(PAD_T), .PAD_B(PAD_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
  .video_on(video_on), .rgb_out(rgb_out),
  .act_cx(act_cx), .act_cy(act_cy), .act_r(act_r)
);

// File: tb/orb_compositor_tb.sv
`timescale 1ns/1ps
module orb_compositor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix_x = '0, pix_y = '0;
  logic       video_on = 1'b0;
  logic       ld_stb = 1'b0;
  logic [9:0] ld_cx = '0, ld_cy = '0, ld_r = '0;
  logic [2:0] rgb_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the disc parameters
  int m_cx = 320, m_cy = 240, m_r = 16;
  int p_cx, p_cy, p_r;
  bit p_vld = 1'b0;

  logic [2:0] h_exp [3];
  string      h_tag [3];
  int         h_cnt = 0;

  always #4 clk = ~clk;

  orb_compositor u_dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .video_on(video_on), .ld_stb(ld_stb), .ld_cx(ld_cx), .ld_cy(ld_cy),
    .ld_r(ld_r), .rgb_out(rgb_out)
  );

  function automatic logic [2:0] ref_rgb(int x, int y, bit v, int cx, int cy,
                                         int r, output string tag);
    int dx = x - cx;
    int dy = y - cy;
    if (!v) begin tag = "R3"; return 3'b000; end
    if (x >= 32 && x <= 35) begin tag = "R4"; return 3'b001; end
    if (x >= 600 && x <= 603 && y >= 204 && y <= 275) begin tag = "R5"; return 3'b010; end
    if (dx*dx + dy*dy <= r*r) begin tag = (r == 0) ? "R11" : "R6"; return 3'b100; end
    tag = "R7";
    return 3'b110;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rgb_out=%b expected=%b", tag, act, exp);
    end
  endtask

  // One pixel per clock; compares the colour due from three pixels earlier (R2).
  task automatic px(int x, int y, bit v, string force_tag = "",
                    bit ld = 1'b0, int ncx = 0, int ncy = 0, int nr = 0);
    logic [2:0] e;
    string t;
    @(negedge clk);
    if (h_cnt >= 3) check({h_tag[2], "/R2"}, rgb_out, h_exp[2]);
    if (x == 0 && y == 0 && p_vld) begin
      m_cx = p_cx; m_cy = p_cy; m_r = p_r; p_vld = 1'b0;
    end
    e = ref_rgb(x, y, v, m_cx, m_cy, m_r, t);
    if (force_tag != "") t = force_tag;
    pix_x = 10'(x); pix_y = 10'(y); video_on = v;
    ld_stb = ld; ld_cx = 10'(ncx); ld_cy = 10'(ncy); ld_r = 10'(nr);
    if (ld) begin p_cx = ncx; p_cy = ncy; p_r = nr; p_vld = 1'b1; end
    h_exp[2] = h_exp[1]; h_tag[2] = h_tag[1];
    h_exp[1] = h_exp[0]; h_tag[1] = h_tag[0];
    h_exp[0] = e;        h_tag[0] = t;
    if (h_cnt < 3) h_cnt++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", rgb_out, 3'b000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", rgb_out, 3'b000);

    // reset parameters of the disc
    px(320, 240, 1, "R10");
    px(336, 240, 1, "R10");
    px(337, 240, 1, "R10");
    px(320, 224, 1, "R10");
    // blanking over shapes
    px(33, 100, 0);
    px(320, 240, 0);
    px(601, 240, 0);
    // wall edges
    px(31, 10, 1); px(32, 0, 1); px(35, 479, 1); px(36, 300, 1);
    // paddle edges
    px(599, 240, 1); px(600, 204, 1); px(603, 275, 1); px(604, 240, 1);
    px(601, 203, 1); px(601, 276, 1);
    // disc boundary at the reset values
    px(331, 251, 1); px(332, 252, 1); px(304, 240, 1); px(303, 240, 1);
    px(320, 256, 1); px(320, 257, 1); px(309, 229, 1);

    // deferred load: no effect mid-frame
    px(10, 10, 1, "", 1'b1, 610, 240, 12);
    px(610, 240, 1, "R8");
    px(320, 240, 1, "R8");
    px(0, 0, 1, "R8");
    px(610, 240, 1, "R8");
    px(601, 240, 1);
    px(598, 240, 1);
    px(597, 240, 1);

    // strobe in the frame-start cycle waits for the next frame start
    px(0, 0, 1, "R9", 1'b1, 30, 100, 10);
    px(30, 100, 1, "R9");
    px(610, 240, 1, "R9");
    px(0, 0, 1, "R9");
    px(30, 100, 1, "R9");
    px(33, 100, 1);
    px(20, 100, 1);
    // last strobe wins
    px(5, 5, 1, "", 1'b1, 100, 100, 5);
    px(6, 5, 1, "", 1'b1, 200, 200, 5);
    px(0, 0, 1, "R9");
    px(100, 100, 1, "R9");
    px(200, 200, 1, "R9");
    px(205, 200, 1, "R9");

    // single-pixel disc
    px(1, 1, 1, "", 1'b1, 50, 50, 0);
    px(0, 0, 1);
    px(50, 50, 1, "R11");
    px(51, 50, 1, "R11");
    px(50, 49, 1, "R11");

    // disc at the origin: lower box limits below zero
    px(1, 1, 1, "", 1'b1, 0, 0, 6);
    px(0, 0, 1, "R6");
    px(6, 0, 1, "R6");
    px(7, 0, 1, "R6");
    px(4, 4, 1, "R6");
    px(5, 4, 1, "R6");

    // random pixels with occasional reloads and frame starts
    for (int i = 0; i < 6000; i++) begin
      int x, y, sel;
      bit v, ld;
      sel = int'($urandom_range(0, 99));
      v  = ($urandom_range(0, 9) != 0);
      ld = ($urandom_range(0, 149) == 0);
      if (sel < 30) begin
        x = m_cx + int'($urandom_range(0, 2*m_r + 4)) - m_r - 2;
        y = m_cy + int'($urandom_range(0, 2*m_r + 4)) - m_r - 2;
        if (x < 0) x = 0; if (x > 639) x = 639;
        if (y < 0) y = 0; if (y > 479) y = 479;
      end else if (sel < 33) begin
        x = 0; y = 0;
      end else begin
        x = int'($urandom_range(0, 639));
        y = int'($urandom_range(0, 479));
      end
      if (ld)
        px(x, y, v, "", 1'b1, int'($urandom_range(0, 639)),
           int'($urandom_range(0, 479)), int'($urandom_range(0, 63)));
      else
        px(x, y, v);
    end
    px(0, 1, 0); px(0, 1, 0); px(0, 1, 0);
    @(negedge clk);
    check({h_tag[2], "/R2"}, rgb_out, h_exp[2]);
    finish_run();
  end
endmodule